// File: doc/BRIEF.md
# Keyed Nonlinear Controlled Substitution-Permutation Box

This block is a purely combinational 64-bit data-dependent operation. A 64-bit word passes through six layers of small nonlinear controlled cells, each cell taking two data bits and two control bits. Fixed wiring sits between the layers, and a fixed 8x8 bit transpose sits in the centre. A 384-bit control word sets every cell in every layer, so the box behaves as a keyed nonlinear transform whose key changes from use to use. A single mode pin picks the forward transform or its exact inverse. The inverse runs on the same hardware: only the order in which the six layer controls are applied changes.

The control word holds six layer controls of 64 bits each. Layer j (j = 1..6) uses bits [64(j-1)+63 : 64(j-1)]. The low 32 bits of a layer control are the V vector and the high 32 bits are the Z vector. Bit e of V and bit e of Z drive cell e of that layer, which takes data bits 2e (x1) and 2e+1 (x2) of the layer input and writes them back to the same positions. The datapath is three layers in a forward half, then the transpose, then three layers in a mirrored half. Each half is eight independent 8-bit sub-boxes, and sub-box s covers bits 8s..8s+7. Between the layers of the forward half, each sub-box applies an interleave: output bit 2i takes input bit i, and output bit 2i+1 takes input bit i+4. The mirrored half applies the matching de-interleave instead.

Top module: `cspn_box`

## Requirements
- R1: Each cell maps (x1,x2) to a pair (y1,y2) chosen by its controls (v,z). For v=0,z=0 the result is (x2,x1). For v=0,z=1 it is (x1^x2^1, x2). For v=1,z=0 it is (x1, x1^x2). For v=1,z=1 it is (~x2, ~x1).
- R2: With an all-zero control word, each cell only swaps its pair, so the output is a bit permutation of the input: an all-zero input gives an all-zero output and a single set bit gives a single set bit.
- R3: With inv_i=0 the output equals L1,P,L2,P,L3,T,L6,Q,L5,Q,L4 applied in that order. Here Lj is layer j with its control, P is the per-sub-box interleave, Q is the de-interleave, and T swaps bit 8a+b with bit 8b+a (a,b = 0..7).
- R4: With inv_i=1 the output equals L4,P,L5,P,L6,T,L3,Q,L2,Q,L1 applied in that order.
- R5: For any data x and control C, feeding the forward output back with inv_i=1 and the same C returns x.
- R6: For any data x and control C, feeding the inverse output back with inv_i=0 and the same C returns x.
- R7: With an all-ones control word, each cell swaps and complements its pair. Six layers cancel the complements, so the output keeps the population count of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Data word to transform |
| ctl_i | input | 384 | Six 64-bit layer controls, layer 1 in the low bits |
| inv_i | input | 1 | 0 selects the forward transform, 1 selects the inverse |
| data_o | output | 64 | Transformed word, settled in the same cycle |

## Verification
The block holds no state, so any fault shows on data_o as soon as the inputs settle. A miswired control bit or cell shows up as a wrong word against the bench model. The same fault also breaks the round trip, where the inverse no longer restores the original data. Structured control patterns (all zero, all ones, uniform v/z pairs) isolate the cell table. The zero-control case exposes wiring faults in the interleave and transpose, because it leaves the box a pure permutation whose walking-one output must stay one-hot.

// File: rtl/cspn_pkg.sv
package cspn_pkg;
  localparam int DATA_W    = 64;
  localparam int SIDE      = 8;                 // transpose is SIDE x SIDE
  localparam int SUB_W     = 8;
  localparam int N_SUB     = DATA_W / SUB_W;
  localparam int SUB_CELLS = SUB_W / 2;
  localparam int N_CELLS   = DATA_W / 2;
  localparam int N_STAGE   = 3;                 // layers per half
  localparam int CASC_W    = 2 * N_CELLS;       // V then Z
  localparam int HALF_W    = N_STAGE * CASC_W;
  localparam int CTL_W     = 2 * HALF_W;
endpackage

// File: rtl/cspn_cell.sv
module cspn_cell (
  input  logic x1_i,
  input  logic x2_i,
  input  logic v_i,
  input  logic z_i,
  output logic y1_o,
  output logic y2_o
);
  always_comb begin
    y1_o = (v_i & z_i & x2_i) ^ (v_i & x2_i) ^ (v_i & x1_i) ^ (z_i & x1_i) ^ z_i ^ x2_i;
    y2_o = (v_i & z_i & x1_i) ^ (v_i & z_i) ^ (v_i & x2_i) ^ (z_i & x1_i) ^ (z_i & x2_i) ^ x1_i;
  end
endmodule

// File: rtl/cspn_sub.sv
module cspn_sub
  import cspn_pkg::*;
#(
  parameter bit INV = 1'b0  // 1: de-interleave between layers
) (
  input  logic [SUB_W-1:0]             d_i,
  input  logic [N_STAGE*SUB_CELLS-1:0] v_i,
  input  logic [N_STAGE*SUB_CELLS-1:0] z_i,
  output logic [SUB_W-1:0]             d_o
);
  localparam int HALF = SUB_W / 2;

  logic [SUB_W-1:0] st_in  [N_STAGE];
  logic [SUB_W-1:0] st_out [N_STAGE];

  assign st_in[0] = d_i;
  assign d_o      = st_out[N_STAGE-1];

  for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
    for (genvar e = 0; e < SUB_CELLS; e++) begin : g_cell
      cspn_cell u_cell (
        .x1_i (st_in[k][2*e]),
        .x2_i (st_in[k][2*e+1]),
        .v_i  (v_i[k*SUB_CELLS+e]),
        .z_i  (z_i[k*SUB_CELLS+e]),
        .y1_o (st_out[k][2*e]),
        .y2_o (st_out[k][2*e+1])
      );
    end
    if (k < N_STAGE-1) begin : g_wire
      for (genvar i = 0; i < HALF; i++) begin : g_bit
        if (!INV) begin : g_shuf
          assign st_in[k+1][2*i]   = st_out[k][i];
          assign st_in[k+1][2*i+1] = st_out[k][i+HALF];
        end else begin : g_unshuf
          assign st_in[k+1][i]      = st_out[k][2*i];
          assign st_in[k+1][i+HALF] = st_out[k][2*i+1];
        end
      end
    end
  end
endmodule

// File: rtl/cspn_half.sv
module cspn_half
  import cspn_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic [HALF_W-1:0] ctl_i,  // stage k at [k*CASC_W +: CASC_W], applied in k order
  output logic [DATA_W-1:0] d_o
);
  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    logic [N_STAGE*SUB_CELLS-1:0] v_s, z_s;
    for (genvar k = 0; k < N_STAGE; k++) begin : g_map
      assign v_s[k*SUB_CELLS +: SUB_CELLS] = ctl_i[k*CASC_W + s*SUB_CELLS +: SUB_CELLS];
      assign z_s[k*SUB_CELLS +: SUB_CELLS] = ctl_i[k*CASC_W + N_CELLS + s*SUB_CELLS +: SUB_CELLS];
    end
    cspn_sub #(.INV(INV)) u_sub (
      .d_i (d_i[s*SUB_W +: SUB_W]),
      .v_i (v_s),
      .z_i (z_s),
      .d_o (d_o[s*SUB_W +: SUB_W])
    );
  end
endmodule

// File: rtl/cspn_transpose.sv
module cspn_transpose
  import cspn_pkg::*;
(
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  for (genvar a = 0; a < SIDE; a++) begin : g_row
    for (genvar b = 0; b < SIDE; b++) begin : g_col
      assign d_o[SIDE*a+b] = d_i[SIDE*b+a];
    end
  end
endmodule

// File: rtl/cspn_box.sv
module cspn_box
  import cspn_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] data_o
);
  logic [HALF_W-1:0] ctl_lo, ctl_hi, ctl_hi_rev, ctl_lo_rev;
  logic [HALF_W-1:0] ctl_a, ctl_b;
  logic [DATA_W-1:0] a_out, mid;

  assign ctl_lo = ctl_i[HALF_W-1:0];
  assign ctl_hi = ctl_i[CTL_W-1:HALF_W];

  for (genvar k = 0; k < N_STAGE; k++) begin : g_rev
    assign ctl_hi_rev[k*CASC_W +: CASC_W] = ctl_hi[(N_STAGE-1-k)*CASC_W +: CASC_W];
    assign ctl_lo_rev[k*CASC_W +: CASC_W] = ctl_lo[(N_STAGE-1-k)*CASC_W +: CASC_W];
  end

  // mirror symmetry: inverse reuses the datapath with layers 4..6 first
  assign ctl_a = inv_i ? ctl_hi     : ctl_lo;
  assign ctl_b = inv_i ? ctl_lo_rev : ctl_hi_rev;

  cspn_half #(.INV(1'b0)) u_half_a (.d_i(data_i), .ctl_i(ctl_a), .d_o(a_out));
  cspn_transpose          u_mid    (.d_i(a_out),  .d_o(mid));
  cspn_half #(.INV(1'b1)) u_half_b (.d_i(mid),    .ctl_i(ctl_b), .d_o(data_o));
endmodule

// File: rtl/cspn_box_chk.sv
module cspn_box_chk
  import cspn_pkg::*;
(
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] a_out,
  input logic [DATA_W-1:0] mid,
  input logic [DATA_W-1:0] data_o,
  input logic [HALF_W-1:0] ctl_a,
  input logic [HALF_W-1:0] ctl_b
);
  logic [HALF_W-1:0] ra, rb;
  logic [DATA_W-1:0] back_a, back_b;
  logic              diag_ok;

  for (genvar k = 0; k < N_STAGE; k++) begin : g_rev
    assign ra[k*CASC_W +: CASC_W] = ctl_a[(N_STAGE-1-k)*CASC_W +: CASC_W];
    assign rb[k*CASC_W +: CASC_W] = ctl_b[(N_STAGE-1-k)*CASC_W +: CASC_W];
  end

  cspn_half #(.INV(1'b1)) u_undo_a (.d_i(a_out),  .ctl_i(ra), .d_o(back_a));
  cspn_half #(.INV(1'b0)) u_undo_b (.d_i(data_o), .ctl_i(rb), .d_o(back_b));

  always_comb begin
    diag_ok = 1'b1;
    for (int k = 0; k < SIDE; k++) diag_ok &= (mid[(SIDE+1)*k] == a_out[(SIDE+1)*k]);
  end

  always_comb begin
    AST_HALF_A_UNDO: assert (back_a == data_i) else $error("first half not invertible"); // R5
    AST_HALF_B_UNDO: assert (back_b == mid) else $error("second half not invertible"); // R6
    AST_MID_DIAG: assert (diag_ok) else $error("transpose moved a diagonal bit"); // R3
    AST_MID_WEIGHT: assert ($countones(mid) == $countones(a_out)) else $error("transpose changed weight"); // R2
  end
endmodule

bind cspn_box cspn_box_chk u_chk (
  .data_i (data_i),
  .a_out  (a_out),
  .mid    (mid),
  .data_o (data_o),
  .ctl_a  (ctl_a),
  .ctl_b  (ctl_b)
);

// File: tb/cspn_box_tb_top.sv
`timescale 1ns/1ps
module cspn_box_tb_top;
  logic         clk = 1'b0;
  logic [63:0]  data_i = '0;
  logic [383:0] ctl_i = '0;
  logic         inv_i = 1'b0;
  logic [63:0]  data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] exp;
    int          wt;   // expected popcount, -1 when unused
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  cspn_box dut_i (.data_i(data_i), .ctl_i(ctl_i), .inv_i(inv_i), .data_o(data_o));

  function automatic logic [1:0] m_cell(logic x1, logic x2, logic v, logic z);
    case ({v, z})
      2'b00:   return {x1, x2};               // {y2,y1}
      2'b01:   return {x2, x1 ^ x2 ^ 1'b1};
      2'b10:   return {x1 ^ x2, x1};
      default: return {~x1, ~x2};
    endcase
  endfunction

  function automatic logic [63:0] m_layer(logic [63:0] d, logic [63:0] c);
    logic [63:0] r;
    for (int e = 0; e < 32; e++) begin
      logic [1:0] y;
      y = m_cell(d[2*e], d[2*e+1], c[e], c[32+e]);
      r[2*e]   = y[0];
      r[2*e+1] = y[1];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_shuf(logic [63:0] d, bit un);
    logic [63:0] r;
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 4; i++) begin
        if (!un) begin
          r[8*s+2*i]   = d[8*s+i];
          r[8*s+2*i+1] = d[8*s+i+4];
        end else begin
          r[8*s+i]   = d[8*s+2*i];
          r[8*s+i+4] = d[8*s+2*i+1];
        end
      end
    return r;
  endfunction

  function automatic logic [63:0] m_tr(logic [63:0] d);
    logic [63:0] r;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) r[8*a+b] = d[8*b+a];
    return r;
  endfunction

  function automatic logic [63:0] m_box(logic [63:0] d, logic [383:0] c, bit inv);
    int ord[6];
    logic [63:0] r;
    if (!inv) ord = '{1, 2, 3, 6, 5, 4};
    else      ord = '{4, 5, 6, 3, 2, 1};
    r = d;
    for (int k = 0; k < 6; k++) begin
      r = m_layer(r, c[64*(ord[k]-1) +: 64]);
      if (k == 0 || k == 1) r = m_shuf(r, 1'b0);
      if (k == 2)           r = m_tr(r);
      if (k == 3 || k == 4) r = m_shuf(r, 1'b1);
    end
    return r;
  endfunction

  task automatic apply(logic [63:0] d, logic [383:0] c, bit inv,
                       logic [63:0] exp, int wt, string tag);
    item_t it;
    @(posedge clk);
    #1;
    data_i = d;
    ctl_i  = c;
    inv_i  = inv;
    it.exp = exp;
    it.wt  = wt;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (data_o !== it.exp) begin
        errors++;
        $display("FAIL %s: data_o=%h expected %h", it.tag, data_o, it.exp);
      end
      if (it.wt >= 0) begin
        checks++;
        if ($countones(data_o) != it.wt) begin
          errors++;
          $display("FAIL %s: weight=%0d expected %0d", it.tag, $countones(data_o), it.wt);
        end
      end
    end
  end

  function automatic logic [383:0] rnd_ctl();
    logic [383:0] c;
    for (int i = 0; i < 12; i++) c[32*i +: 32] = $urandom();
    return c;
  endfunction

  initial begin
    logic [383:0] c;
    logic [63:0]  x, y;
    // R2: zero control, zero data gives zero
    apply('0, '0, 1'b0, 64'h0, 0, "R2 zero");
    // R2: walking one stays one-hot under zero control
    for (int b = 0; b < 64; b += 7) begin
      x = 64'h1 << b;
      apply(x, '0, 1'b0, m_box(x, '0, 1'b0), 1, "R2 walk");
    end
    // R1: uniform control per v,z combination
    for (int vz = 0; vz < 4; vz++) begin
      for (int j = 0; j < 6; j++) begin
        c[64*j +: 32]    = {32{vz[1]}};
        c[64*j+32 +: 32] = {32{vz[0]}};
      end
      for (int n = 0; n < 4; n++) begin
        x = {$urandom(), $urandom()};
        apply(x, c, 1'b0, m_box(x, c, 1'b0), -1, "R1 fwd");
        apply(x, c, 1'b1, m_box(x, c, 1'b1), -1, "R1 inv");
      end
    end
    // R7: all-ones control preserves weight
    for (int n = 0; n < 6; n++) begin
      x = {$urandom(), $urandom()};
      apply(x, '1, 1'b0, m_box(x, '1, 1'b0), $countones(x), "R7 ones");
    end
    // R3 R4 R5 R6: random controls and data
    for (int n = 0; n < 150; n++) begin
      c = rnd_ctl();
      x = {$urandom(), $urandom()};
      y = m_box(x, c, 1'b0);
      apply(x, c, 1'b0, y, -1, "R3 fwd");
      apply(y, c, 1'b1, x, -1, "R5 roundtrip");
      y = m_box(x, c, 1'b1);
      apply(x, c, 1'b1, y, -1, "R4 inv");
      apply(y, c, 1'b0, x, -1, "R6 roundtrip");
    end
    // single control bit isolation
    for (int b = 0; b < 384; b += 37) begin
      c = '0;
      c[b] = 1'b1;
      x = 64'hF0E1_D2C3_B4A5_9687;
      apply(x, c, 1'b0, m_box(x, c, 1'b0), -1, "R3 ctlbit");
      apply(m_box(x, c, 1'b0), c, 1'b1, x, -1, "R5 ctlbit");
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule